// File: doc/BRIEF.md
# Multichannel DAC Serial Register Front End

This block is the digital receiving end of a multichannel digital-to-analog converter. A host talks to it over a four-wire serial port in clock-polarity-0/phase-0 mode. Every transaction is a 24-bit word, most significant bit first. The top two bits select an operation. The next six bits give a register address, and the low sixteen bits are the payload. The block keeps a data, an offset and a gain register for each channel. It also keeps a small special-function space: a control word, a few offset registers that are shared by groups of channels, and a readback request.

The serial pins are brought into the core clock domain through two-flop synchronisers. Edges are detected there. A word takes effect only when chip select returns high after exactly 24 serial clocks. Readback takes two words. The first word names a register. The second word, sent with chip select toggled in between, carries that register's value out on the data-out pin. The analog side receives each channel's code, the effective shared offset for each channel, and a global power-down flag.

Top module: `dacif_top`

## Requirements
- R1: A word is committed only when chip select rises after exactly 24 rising serial-clock edges. Bits [23:22] are the operation, [21:16] the address and [15:0] the payload. A word of any other length leaves every register unchanged.
- R2: Operation 3 writes the payload into the primary data register of channel n, at address 8+n. That register drives the channel's 16-bit code output.
- R3: Operation 2 writes the channel offset register and operation 1 writes the channel gain register, both at address 8+n. Readback types 2 and 3 return them.
- R4: After reset, every primary data, secondary data and channel offset register reads 0x8000. Every gain register reads 0xFFFF. The control word is 0, and every shared offset register reads 0x2000.
- R5: Operation 0 at address 1 loads the control word. Bit 0 of the control word drives the power-down output.
- R6: Operation 0 at addresses 2, 3 and 4 loads shared offset registers 0, 1 and 2 with payload bits [13:0]. Channel n uses shared offset register min(n/8, 2).
- R7: Operation 0 at address 5 is a readback request. Bits [15:13] give the type: 0 for primary data, 1 for secondary data, 2 for offset, 3 for gain and 4 for the special-function space. Bits [12:7] give the address. The next word shifts out eight zero bits, then the 16-bit value as it stood when that word's chip select fell.
- R8: A readback request applies only to the word that immediately follows it. Every other word shifts out all zeros.
- R9: While chip select is high, the data-out enable is low and the data-out pin is 0.
- R10: A write to an address that maps to no register changes nothing. This covers a channel operation below 8 or above the last channel, and special-function address 0.
- R11: Readback type 1 returns the secondary data register. That register stays 0x8000 whatever is written with operation 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for serial data out |
| pwr_down_o | output | 1 | Global power-down flag |
| ch_code_o | output | NCH*16 | Per-channel codes, channel n at [16n+15:16n] |
| ch_gofs_o | output | NCH*14 | Effective shared offset per channel, channel n at [14n+13:14n] |

## Verification
Shifting out a readback value and writing the register being read can happen in the same word. The bench requests a readback of a channel's primary data. It then sends, as the following word, a write of a new value to that same channel. The bits shifted out must be the old value, because the value is captured when chip select falls. The channel code must show the new value once chip select has risen.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  localparam int FRAME_W = 24;
  localparam int CH_BASE = 8;

  typedef enum logic [1:0] {
    OP_SF   = 2'd0,
    OP_GAIN = 2'd1,
    OP_OFS  = 2'd2,
    OP_DATA = 2'd3
  } op_e;

  localparam logic [5:0] SF_NOP   = 6'd0;
  localparam logic [5:0] SF_CTRL  = 6'd1;
  localparam int         SF_GOFS0 = 2;
  localparam logic [5:0] SF_RDREQ = 6'd5;

  localparam logic [2:0] RB_DAT_A = 3'd0;
  localparam logic [2:0] RB_DAT_B = 3'd1;
  localparam logic [2:0] RB_OFS   = 3'd2;
  localparam logic [2:0] RB_GAIN  = 3'd3;
  localparam logic [2:0] RB_SF    = 3'd4;

  localparam logic [15:0] MID_CODE  = 16'h8000;
  localparam logic [15:0] FULL_CODE = 16'hFFFF;
  localparam logic [13:0] MID_GOFS  = 14'h2000;

  typedef struct packed {
    op_e         op;
    logic [5:0]  addr;
    logic [15:0] data;
  } frame_t;

endpackage

// File: rtl/dacif_spi_port.sv
module dacif_spi_port
  import dacif_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_i,
  input  logic               csn_i,
  input  logic               mosi_i,
  input  logic [15:0]        tx_word_i,
  input  logic               tx_valid_i,
  output logic               miso_o,
  output logic               miso_oe_o,
  output logic               commit_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               load_o
);

  localparam int CNT_W = $clog2(FRAME_W + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic csn_m, csn_s, csn_p;
  logic sclk_m, sclk_s, sclk_p;
  logic mosi_m, mosi_s;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;

  logic cs_act, cs_fall, cs_rise, sck_rise, sck_fall;

  // synchronisers and edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_m  <= 1'b1;
      csn_s  <= 1'b1;
      csn_p  <= 1'b1;
      sclk_m <= 1'b0;
      sclk_s <= 1'b0;
      sclk_p <= 1'b0;
      mosi_m <= 1'b0;
      mosi_s <= 1'b0;
    end else begin
      csn_m  <= csn_i;
      csn_s  <= csn_m;
      csn_p  <= csn_s;
      sclk_m <= sclk_i;
      sclk_s <= sclk_m;
      sclk_p <= sclk_s;
      mosi_m <= mosi_i;
      mosi_s <= mosi_m;
    end
  end

  assign cs_act   = ~csn_s;
  assign cs_fall  = csn_p & ~csn_s;
  assign cs_rise  = ~csn_p & csn_s;
  assign sck_rise = cs_act & sclk_s & ~sclk_p;
  assign sck_fall = cs_act & ~sclk_s & sclk_p;

  always_comb begin
    rx_d  = rx_q;
    cnt_d = cnt_q;
    tx_d  = tx_q;
    if (cs_fall) begin
      cnt_d = '0;
      tx_d  = {8'h00, (tx_valid_i ? tx_word_i : 16'h0000)};
    end else begin
      if (sck_rise) begin
        rx_d = {rx_q[FRAME_W-2:0], mosi_s};
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
      if (sck_fall) tx_d = {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      tx_q  <= '0;
      cnt_q <= '0;
    end else begin
      rx_q  <= rx_d;
      tx_q  <= tx_d;
      cnt_q <= cnt_d;
    end
  end

  assign commit_o  = cs_rise && (cnt_q == CNT_W'(FRAME_W));
  assign frame_o   = rx_q;
  assign load_o    = cs_fall;
  assign miso_o    = cs_act & tx_q[FRAME_W-1];
  assign miso_oe_o = cs_act;

endmodule

// File: rtl/dacif_regfile.sv
module dacif_regfile
  import dacif_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int GRP_SIZE = 8,
  parameter int NGOFS    = 3,
  parameter int GOFS_W   = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_i,
  input  logic [FRAME_W-1:0]     frame_i,
  input  logic                   load_i,
  output logic [15:0]            rb_word_o,
  output logic                   rb_valid_o,
  output logic                   pwr_down_o,
  output logic [NCH*16-1:0]      code_o,
  output logic [NCH*GOFS_W-1:0]  gofs_o
);

  frame_t frm;
  assign frm = frame_t'(frame_i);

  logic [NCH-1:0][15:0] dat_a_v, ofs_v, gain_v;

  logic [15:0]                   ctrl_q, ctrl_d;
  logic [NGOFS-1:0][GOFS_W-1:0]  gofs_q, gofs_d;
  logic                          rb_pend_q, rb_pend_d;
  logic [2:0]                    rb_type_q, rb_type_d;
  logic [5:0]                    rb_addr_q, rb_addr_d;

  logic sf_wr;
  assign sf_wr = commit_i && (frm.op == OP_SF);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [5:0] ADR = 6'(CH_BASE + g);
    localparam int GRP = g / GRP_SIZE;
    localparam int GSEL = (GRP >= NGOFS) ? NGOFS - 1 : GRP;
    logic        hit, we_a, we_o, we_g;
    logic [15:0] dat_a_q, ofs_q, gain_q;

    assign hit  = commit_i && (frm.addr == ADR);
    assign we_a = hit && (frm.op == OP_DATA);
    assign we_o = hit && (frm.op == OP_OFS);
    assign we_g = hit && (frm.op == OP_GAIN);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat_a_q <= MID_CODE;
        ofs_q   <= MID_CODE;
        gain_q  <= FULL_CODE;
      end else begin
        if (we_a) dat_a_q <= frm.data;
        if (we_o) ofs_q   <= frm.data;
        if (we_g) gain_q  <= frm.data;
      end
    end

    assign dat_a_v[g] = dat_a_q;
    assign ofs_v[g]   = ofs_q;
    assign gain_v[g]  = gain_q;
    assign gofs_o[g*GOFS_W +: GOFS_W] = gofs_q[GSEL];
  end

  // special-function next state
  always_comb begin
    ctrl_d    = ctrl_q;
    gofs_d    = gofs_q;
    rb_pend_d = rb_pend_q;
    rb_type_d = rb_type_q;
    rb_addr_d = rb_addr_q;
    if (load_i) rb_pend_d = 1'b0;
    if (sf_wr) begin
      if (frm.addr == SF_CTRL) ctrl_d = frm.data;
      for (int k = 0; k < NGOFS; k++) begin
        if (frm.addr == 6'(SF_GOFS0 + k)) gofs_d[k] = frm.data[GOFS_W-1:0];
      end
      if (frm.addr == SF_RDREQ) begin
        rb_pend_d = 1'b1;
        rb_type_d = frm.data[15:13];
        rb_addr_d = frm.data[12:7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      gofs_q    <= {NGOFS{MID_GOFS}};
      rb_pend_q <= 1'b0;
      rb_type_q <= '0;
      rb_addr_q <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      gofs_q    <= gofs_d;
      rb_pend_q <= rb_pend_d;
      rb_type_q <= rb_type_d;
      rb_addr_q <= rb_addr_d;
    end
  end

  // readback selection
  always_comb begin
    rb_word_o = '0;
    for (int n = 0; n < NCH; n++) begin
      if (rb_addr_q == 6'(CH_BASE + n)) begin
        case (rb_type_q)
          RB_DAT_A: rb_word_o = dat_a_v[n];
          RB_DAT_B: rb_word_o = MID_CODE;
          RB_OFS:   rb_word_o = ofs_v[n];
          RB_GAIN:  rb_word_o = gain_v[n];
          default:  ;
        endcase
      end
    end
    if (rb_type_q == RB_SF) begin
      if (rb_addr_q == SF_CTRL) rb_word_o = ctrl_q;
      for (int k = 0; k < NGOFS; k++) begin
        if (rb_addr_q == 6'(SF_GOFS0 + k)) rb_word_o = 16'(gofs_q[k]);
      end
    end
  end

  assign rb_valid_o = rb_pend_q;
  assign pwr_down_o = ctrl_q[0];
  assign code_o     = dat_a_v;

endmodule

// File: rtl/dacif_top.sv
module dacif_top
  import dacif_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int GRP_SIZE = 8,
  parameter int NGOFS    = 3,
  parameter int GOFS_W   = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spi_sclk,
  input  logic                  spi_csn,
  input  logic                  spi_mosi,
  output logic                  spi_miso,
  output logic                  spi_miso_oe,
  output logic                  pwr_down_o,
  output logic [NCH*16-1:0]     ch_code_o,
  output logic [NCH*GOFS_W-1:0] ch_gofs_o
);

  logic               commit_w, load_w, rb_valid_w;
  logic [FRAME_W-1:0] frame_w;
  logic [15:0]        rb_word_w;

  dacif_spi_port u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_i     (spi_sclk),
    .csn_i      (spi_csn),
    .mosi_i     (spi_mosi),
    .tx_word_i  (rb_word_w),
    .tx_valid_i (rb_valid_w),
    .miso_o     (spi_miso),
    .miso_oe_o  (spi_miso_oe),
    .commit_o   (commit_w),
    .frame_o    (frame_w),
    .load_o     (load_w)
  );

  dacif_regfile #(
    .NCH      (NCH),
    .GRP_SIZE (GRP_SIZE),
    .NGOFS    (NGOFS),
    .GOFS_W   (GOFS_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_i   (commit_w),
    .frame_i    (frame_w),
    .load_i     (load_w),
    .rb_word_o  (rb_word_w),
    .rb_valid_o (rb_valid_w),
    .pwr_down_o (pwr_down_o),
    .code_o     (ch_code_o),
    .gofs_o     (ch_gofs_o)
  );

endmodule

// File: rtl/dacif_chk.sv
module dacif_chk #(
  parameter int NCH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic              pwr_down_o,
  input logic [NCH*16-1:0] ch_code_o,
  input logic              commit,
  input logic [1:0]        frm_op,
  input logic [5:0]        frm_addr,
  input logic              frm_bit0
);

  logic ctrl_wr;
  assign ctrl_wr = commit && (frm_op == 2'd0) && (frm_addr == 6'd1);

  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R1

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ch_code_o)); // R1

  AST_PWRDN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (pwr_down_o == $past(frm_bit0))); // R5

  AST_PWRDN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(pwr_down_o)); // R5

  AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_miso_oe |-> !spi_miso); // R9

endmodule

bind dacif_top dacif_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spi_miso    (spi_miso),
  .spi_miso_oe (spi_miso_oe),
  .pwr_down_o  (pwr_down_o),
  .ch_code_o   (ch_code_o),
  .commit      (commit_w),
  .frm_op      (frame_w[23:22]),
  .frm_addr    (frame_w[21:16]),
  .frm_bit0    (frame_w[0])
);

// File: tb/tb_dacif_top.sv
module tb_dacif_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 32;
  localparam int HP         = 6;

  logic clk = 1'b0;
  logic rst_n, spi_sclk, spi_csn, spi_mosi;
  logic spi_miso, spi_miso_oe, pwr_down_o;
  logic [NCH*16-1:0] ch_code_o;
  logic [NCH*14-1:0] ch_gofs_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacif_top #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .pwr_down_o(pwr_down_o), .ch_code_o(ch_code_o), .ch_gofs_o(ch_gofs_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] code(input int n);
    return ch_code_o[n*16 +: 16];
  endfunction

  function automatic logic [13:0] gofs(input int n);
    return ch_gofs_o[n*14 +: 14];
  endfunction

  task automatic xfer(input logic [23:0] w, input int nb, output logic [23:0] r);
    r = '0;
    spi_csn = 1'b0;
    wclk(HP);
    for (int i = 0; i < nb; i++) begin
      spi_mosi = (i < 24) ? w[23-i] : 1'b0;
      wclk(HP);
      r = {r[22:0], spi_miso};
      spi_sclk = 1'b1;
      wclk(HP);
      spi_sclk = 1'b0;
    end
    wclk(HP);
    spi_csn = 1'b1;
    wclk(2*HP);
  endtask

  task automatic wr(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
    logic [23:0] r;
    xfer({op, a, d}, 24, r);
  endtask

  task automatic rdback(input logic [2:0] t, input logic [5:0] a, output logic [23:0] r);
    logic [23:0] dummy;
    xfer({2'd0, 6'd5, t, a, 7'd0}, 24, dummy);
    xfer(24'h0, 24, r);
  endtask

  task automatic t_reset;
    logic [23:0] r;
    chk("R4", "code ch0", code(0), 16'h8000);
    chk("R4", "code ch31", code(31), 16'h8000);
    chk("R4", "pwr_down", pwr_down_o, 0);
    chk("R4", "gofs ch0", gofs(0), 14'h2000);
    chk("R9", "miso_oe idle", spi_miso_oe, 0);
    chk("R9", "miso idle", spi_miso, 0);
    rdback(3'd3, 6'd11, r);
    chk("R4", "gain ch3", r, 24'h00FFFF);
    rdback(3'd2, 6'd11, r);
    chk("R4", "offset ch3", r, 24'h008000);
    rdback(3'd4, 6'd1, r);
    chk("R4", "ctrl", r, 24'h000000);
    rdback(3'd4, 6'd2, r);
    chk("R4", "group offset 0", r, 24'h002000);
  endtask

  task automatic t_data;
    logic [23:0] r;
    wr(2'd3, 6'(8+5), 16'h1234);
    chk("R2", "code ch5", code(5), 16'h1234);
    chk("R2", "code ch4 untouched", code(4), 16'h8000);
    wr(2'd3, 6'(8+31), 16'hA5A5);
    chk("R2", "code ch31", code(31), 16'hA5A5);
    rdback(3'd0, 6'(8+5), r);
    chk("R7", "readback data A ch5 with zero top byte", r, 24'h001234);
  endtask

  task automatic t_ofs_gain;
    logic [23:0] r;
    wr(2'd2, 6'(8+7), 16'hABCD);
    wr(2'd1, 6'(8+7), 16'h5555);
    rdback(3'd2, 6'(8+7), r);
    chk("R3", "offset ch7", r, 24'h00ABCD);
    rdback(3'd3, 6'(8+7), r);
    chk("R3", "gain ch7", r, 24'h005555);
    chk("R3", "code ch7 unchanged", code(7), 16'h8000);
  endtask

  task automatic t_pwr;
    logic [23:0] r;
    wr(2'd0, 6'd1, 16'h0001);
    chk("R5", "power-down set", pwr_down_o, 1);
    rdback(3'd4, 6'd1, r);
    chk("R5", "ctrl readback", r, 24'h000001);
    wr(2'd0, 6'd1, 16'h0000);
    chk("R5", "power-down clear", pwr_down_o, 0);
  endtask

  task automatic t_group;
    logic [23:0] r;
    wr(2'd0, 6'd2, 16'h1111);
    wr(2'd0, 6'd3, 16'h2222);
    wr(2'd0, 6'd4, 16'hC123);
    chk("R6", "ch0 -> group reg 0", gofs(0), 14'h1111);
    chk("R6", "ch7 -> group reg 0", gofs(7), 14'h1111);
    chk("R6", "ch8 -> group reg 1", gofs(8), 14'h2222);
    chk("R6", "ch15 -> group reg 1", gofs(15), 14'h2222);
    chk("R6", "ch16 -> last reg", gofs(16), 14'h0123);
    chk("R6", "ch31 -> last reg", gofs(31), 14'h0123);
    rdback(3'd4, 6'd4, r);
    chk("R6", "group reg 2 14-bit", r, 24'h000123);
  endtask

  task automatic t_length;
    logic [23:0] r;
    xfer({2'd3, 6'(8+5), 16'h7777}, 23, r);
    chk("R1", "23-bit word ignored", code(5), 16'h1234);
    xfer({2'd3, 6'(8+5), 16'h7777}, 25, r);
    chk("R1", "25-bit word ignored", code(5), 16'h1234);
    xfer({2'd0, 6'd1, 16'h0001}, 23, r);
    chk("R1", "short ctrl word ignored", pwr_down_o, 0);
  endtask

  task automatic t_unmapped;
    logic [NCH*16-1:0] c0;
    logic [NCH*14-1:0] g0;
    c0 = ch_code_o;
    g0 = ch_gofs_o;
    wr(2'd3, 6'(8+NCH), 16'h0F0F);
    wr(2'd3, 6'd2, 16'h0F0F);
    wr(2'd2, 6'd3, 16'h0F0F);
    wr(2'd0, 6'd0, 16'hFFFF);
    chk("R10", "codes unchanged", 32'(ch_code_o == c0), 1);
    chk("R10", "group offsets unchanged", 32'(ch_gofs_o == g0), 1);
    chk("R10", "power-down unchanged", pwr_down_o, 0);
  endtask

  task automatic t_dat_b;
    logic [23:0] r;
    rdback(3'd1, 6'(8+5), r);
    chk("R11", "data B ch5", r, 24'h008000);
  endtask

  task automatic t_rb_once;
    logic [23:0] r, dummy;
    xfer({2'd0, 6'd5, 3'd0, 6'(8+5), 7'd0}, 24, dummy);
    xfer({2'd3, 6'(8+5), 16'h0BEE}, 24, r);
    chk("R7", "old value out while same word writes", r, 24'h001234);
    chk("R7", "new code after write", code(5), 16'h0BEE);
    xfer(24'h0, 24, r);
    chk("R8", "word after response is zero", r, 24'h000000);
  endtask

  initial begin
    rst_n = 1'b0; spi_csn = 1'b1; spi_sclk = 1'b0; spi_mosi = 1'b0;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_data();
    t_ofs_gain();
    t_pwr();
    t_group();
    t_length();
    t_unmapped();
    t_dat_b();
    t_rb_once();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule